// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Message Unit

This block sits between two processors that share one clock and lets them trade 32-bit words and doorbell events. Each side owns a small word-addressed register port and one interrupt line. Four data channels run in each direction. A word that one side places in its outgoing slot n lands in the other side's incoming slot n. A full flag on the receiver and an empty flag on the sender track whether the receiver has picked the word up yet.

Each side can also ring any of four doorbells on the opposite side. A ring sets a pending flag on the far side, and that flag stays up until software there clears it by writing a one to it. Every flag has its own enable bit in the local control register. A side's interrupt line is raised whenever any enabled flag is set. Bit fields run backwards, so channel 0 occupies the most significant bit of each four-bit field.

Top module: `ipc_msg_unit`

## Requirements
- R1: The address is a word index (byte offset divided by 4). Index n (0..3) is outgoing slot n, index 4+n is incoming slot n, index 8 is status, index 9 is control, and indices 10..15 are unmapped.
- R2: When one side writes outgoing slot n, from the next cycle the other side's incoming slot n returns that word, its receive-full n bit reads 1 and the writer's transmit-empty n bit reads 0. Reading the writer's own outgoing slot n returns the same word.
- R3: A read returns data in the same cycle and read data is 0 when read enable is low. Reading incoming slot n clears the local receive-full n bit and sets the far side's transmit-empty n bit from the next cycle. If the far side writes slot n in that same cycle, the write wins and the flag stays full.
- R4: The status register holds doorbell-pending n at bit 31-n, receive-full n at bit 27-n and transmit-empty n at bit 23-n. All its other bits read 0.
- R5: The control register holds doorbell-enable n at bit 31-n, receive-enable n at bit 27-n, transmit-enable n at bit 23-n and ring-request n at bit 19-n. All its other bits read 0. A write to control replaces all four fields.
- R6: Writing 1 to ring-request n makes that bit read 1 for exactly the next cycle. In the cycle after that, doorbell-pending n on the opposite side reads 1.
- R7: Writing 1 to a doorbell-pending bit in status clears it and writing 0 leaves it unchanged. If a ring arrives in the same cycle as the clear, the bit stays set.
- R8: The interrupt output is high exactly when, for some channel n, a doorbell-pending, receive-full or transmit-empty bit is set together with its matching enable bit.
- R9: After reset every transmit-empty bit is 1, every receive-full and doorbell-pending bit is 0, control is 0, all data slots are 0 and the interrupt is low.
- R10: Reads at unmapped indices return 0. Writes there, and writes to read-only status bits, change nothing.
- R11: Writing an outgoing slot that is still full replaces the word, and the receiver's full flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_addr | input | 4 | Side A word index |
| a_we | input | 1 | Side A write enable |
| a_wdata | input | 32 | Side A write data |
| a_re | input | 1 | Side A read enable |
| a_rdata | output | 32 | Side A read data |
| a_irq | output | 1 | Side A interrupt |
| b_addr | input | 4 | Side B word index |
| b_we | input | 1 | Side B write enable |
| b_wdata | input | 32 | Side B write data |
| b_re | input | 1 | Side B read enable |
| b_rdata | output | 32 | Side B read data |
| b_irq | output | 1 | Side B interrupt |

## Verification
The hardest cases to reach are the same-cycle collisions between the two ports. These are a write on one side landing in the same cycle as the other side's read of that slot, and a doorbell ring arriving in the same cycle as a write-one clear of that pending bit. Directed steps drive both ports in a single cycle to set up each collision. A long stretch of random two-port traffic, with indices confined to a few slots, then produces many more of them. A behavioural model checks both read buses and both interrupt lines on every cycle.

// File: rtl/ipc_mu_pkg.sv
package ipc_mu_pkg;
    localparam int NCH   = 4;
    localparam int DW    = 32;
    localparam int AW    = 4;
    localparam int FLD_W = NCH;
    // field tops; channel n sits at top - n
    localparam int F_HI0 = 31;
    localparam int F_HI1 = 27;
    localparam int F_HI2 = 23;
    localparam int F_HI3 = 19;
    localparam int IDX_RX   = NCH;
    localparam int IDX_STAT = 2 * NCH;
    localparam int IDX_CTRL = 2 * NCH + 1;

    // channel vector -> reversed field (channel 0 at msb)
    function automatic logic [FLD_W-1:0] to_field(input logic [NCH-1:0] v);
        logic [FLD_W-1:0] f;
        for (int n = 0; n < NCH; n++) f[FLD_W-1-n] = v[n];
        return f;
    endfunction

    function automatic logic [NCH-1:0] from_field(input logic [FLD_W-1:0] f);
        logic [NCH-1:0] v;
        for (int n = 0; n < NCH; n++) v[n] = f[FLD_W-1-n];
        return v;
    endfunction
endpackage

// File: rtl/ipc_mu_chan.sv
module ipc_mu_chan
    import ipc_mu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_word,
    input  logic          pop,
    output logic [DW-1:0] word,
    output logic          full
);
    typedef struct packed {
        logic [DW-1:0] word;
        logic          full;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.word = push_word;
            st_d.full = 1'b1;
        end else if (pop) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = st_q.word;
    assign full = st_q.full;

    assert_push_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (full && word == $past(push_word)));
    assert_pop_drains_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> !full);
    assert_push_over_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push) |=> full);
endmodule

// File: rtl/ipc_mu_side.sv
module ipc_mu_side
    import ipc_mu_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    we,
    input  logic [15:0]             wd_hi,
    input  logic                    re,
    input  logic [NCH-1:0][DW-1:0]  out_word,
    input  logic [NCH-1:0]          out_full,
    input  logic [NCH-1:0][DW-1:0]  in_word,
    input  logic [NCH-1:0]          in_full,
    input  logic [NCH-1:0]          far_ring,
    output logic [NCH-1:0]          push,
    output logic [NCH-1:0]          pop,
    output logic [NCH-1:0]          ring,
    output logic [DW-1:0]           rdata,
    output logic                    irq
);
    typedef struct packed {
        logic [NCH-1:0] db_en;
        logic [NCH-1:0] rx_en;
        logic [NCH-1:0] tx_en;
        logic [NCH-1:0] ring;
        logic [NCH-1:0] pend;
    } side_t;

    side_t st_d, st_q;

    logic wr_ctrl, wr_stat;
    logic [NCH-1:0] clr_mask;
    logic [DW-1:0] stat_word, ctrl_word;

    assign wr_ctrl  = we && (addr == AW'(IDX_CTRL));
    assign wr_stat  = we && (addr == AW'(IDX_STAT));
    assign clr_mask = wr_stat ? from_field(wd_hi[15:12]) : '0;

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_strobe
            assign push[n] = we && (addr == AW'(n));
            assign pop[n]  = re && (addr == AW'(IDX_RX + n));
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        st_d.pend = (st_q.pend & ~clr_mask) | far_ring;
        st_d.ring = '0;
        if (wr_ctrl) begin
            st_d.db_en = from_field(wd_hi[15:12]);
            st_d.rx_en = from_field(wd_hi[11:8]);
            st_d.tx_en = from_field(wd_hi[7:4]);
            st_d.ring  = from_field(wd_hi[3:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        stat_word = '0;
        stat_word[F_HI0 -: FLD_W] = to_field(st_q.pend);
        stat_word[F_HI1 -: FLD_W] = to_field(in_full);
        stat_word[F_HI2 -: FLD_W] = to_field(~out_full);
        ctrl_word = '0;
        ctrl_word[F_HI0 -: FLD_W] = to_field(st_q.db_en);
        ctrl_word[F_HI1 -: FLD_W] = to_field(st_q.rx_en);
        ctrl_word[F_HI2 -: FLD_W] = to_field(st_q.tx_en);
        ctrl_word[F_HI3 -: FLD_W] = to_field(st_q.ring);
    end

    always_comb begin
        rdata = '0;
        if (re) begin
            if (addr < AW'(NCH))              rdata = out_word[addr[1:0]];
            else if (addr < AW'(IDX_STAT))    rdata = in_word[addr[1:0]];
            else if (addr == AW'(IDX_STAT))   rdata = stat_word;
            else if (addr == AW'(IDX_CTRL))   rdata = ctrl_word;
        end
    end

    assign irq = |((st_q.pend & st_q.db_en) | (in_full & st_q.rx_en) | (~out_full & st_q.tx_en));
    assign ring = st_q.ring;

    assert_ring_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (far_ring != '0) |=> ((st_q.pend & $past(far_ring)) == $past(far_ring)));
    assert_ring_one_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> (ring == '0));
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && far_ring == '0) |=> ((st_q.pend & $past(clr_mask)) == '0));
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (re && addr > AW'(IDX_CTRL)) |-> (rdata == '0));
    assert_idle_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !re |-> (rdata == '0));
endmodule

// File: rtl/ipc_msg_unit.sv
module ipc_msg_unit
    import ipc_mu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a_addr,
    input  logic          a_we,
    input  logic [DW-1:0] a_wdata,
    input  logic          a_re,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq,
    input  logic [AW-1:0] b_addr,
    input  logic          b_we,
    input  logic [DW-1:0] b_wdata,
    input  logic          b_re,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq
);
    logic [NCH-1:0][DW-1:0] ab_word, ba_word;
    logic [NCH-1:0]         ab_full, ba_full;
    logic [NCH-1:0]         a_push, a_pop, b_push, b_pop;
    logic [NCH-1:0]         a_ring, b_ring;

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            ipc_mu_chan u_ab (
                .clk(clk), .rst_n(rst_n),
                .push(a_push[n]), .push_word(a_wdata), .pop(b_pop[n]),
                .word(ab_word[n]), .full(ab_full[n])
            );
            ipc_mu_chan u_ba (
                .clk(clk), .rst_n(rst_n),
                .push(b_push[n]), .push_word(b_wdata), .pop(a_pop[n]),
                .word(ba_word[n]), .full(ba_full[n])
            );
        end
    endgenerate

    ipc_mu_side u_side_a (
        .clk(clk), .rst_n(rst_n),
        .addr(a_addr), .we(a_we), .wd_hi(a_wdata[DW-1:DW-16]), .re(a_re),
        .out_word(ab_word), .out_full(ab_full),
        .in_word(ba_word), .in_full(ba_full),
        .far_ring(b_ring),
        .push(a_push), .pop(a_pop), .ring(a_ring),
        .rdata(a_rdata), .irq(a_irq)
    );

    ipc_mu_side u_side_b (
        .clk(clk), .rst_n(rst_n),
        .addr(b_addr), .we(b_we), .wd_hi(b_wdata[DW-1:DW-16]), .re(b_re),
        .out_word(ba_word), .out_full(ba_full),
        .in_word(ab_word), .in_full(ab_full),
        .far_ring(a_ring),
        .push(b_push), .pop(b_pop), .ring(b_ring),
        .rdata(b_rdata), .irq(b_irq)
    );

    assert_cross_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_push != '0) |=> ((ab_full & $past(a_push)) == $past(a_push)));
endmodule

// File: tb/ipc_msg_unit_tb.sv
module ipc_msg_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]  a_addr = '0, b_addr = '0;
    logic        a_we = 1'b0, b_we = 1'b0, a_re = 1'b0, b_re = 1'b0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    always #4 clk = ~clk;

    ipc_msg_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_re(a_re),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_re(b_re),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    // model: full[s][n] = slot n travelling from side s to side 1-s
    bit          m_full [2][4];
    logic [31:0] m_data [2][4];
    bit          m_gie [2][4], m_rie [2][4], m_tie [2][4], m_gir [2][4], m_gip [2][4];

    function automatic logic [31:0] m_status(int s);
        logic [31:0] v = '0;
        for (int n = 0; n < 4; n++) begin
            v[31-n] = m_gip[s][n];
            v[27-n] = m_full[1-s][n];
            v[23-n] = !m_full[s][n];
        end
        return v;
    endfunction

    function automatic logic [31:0] m_ctrl(int s);
        logic [31:0] v = '0;
        for (int n = 0; n < 4; n++) begin
            v[31-n] = m_gie[s][n];
            v[27-n] = m_rie[s][n];
            v[23-n] = m_tie[s][n];
            v[19-n] = m_gir[s][n];
        end
        return v;
    endfunction

    function automatic logic [31:0] m_read(int s, bit re, int ad);
        if (!re) return '0;
        if (ad < 4)  return m_data[s][ad];
        if (ad < 8)  return m_data[1-s][ad-4];
        if (ad == 8) return m_status(s);
        if (ad == 9) return m_ctrl(s);
        return '0;
    endfunction

    function automatic bit m_irq(int s);
        bit r = 1'b0;
        for (int n = 0; n < 4; n++)
            r |= (m_gip[s][n] & m_gie[s][n]) | (m_full[1-s][n] & m_rie[s][n]) |
                 (!m_full[s][n] & m_tie[s][n]);
        return r;
    endfunction

    task automatic cmp32(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 2; s++)
            for (int n = 0; n < 4; n++) begin
                m_full[s][n] = 0; m_data[s][n] = '0;
                m_gie[s][n] = 0; m_rie[s][n] = 0; m_tie[s][n] = 0;
                m_gir[s][n] = 0; m_gip[s][n] = 0;
            end
    endtask

    // inputs are already driven; compare, cross the edge, update model
    task automatic step(string tag);
        bit          we [2], re [2];
        int          ad [2];
        logic [31:0] wd [2];
        bit          nfull [2][4], ngir [2][4], ngip [2][4];
        logic [31:0] ndata [2][4];
        we[0] = a_we; re[0] = a_re; ad[0] = int'(a_addr); wd[0] = a_wdata;
        we[1] = b_we; re[1] = b_re; ad[1] = int'(b_addr); wd[1] = b_wdata;
        #1;
        cmp32(tag, "a_rdata", a_rdata, m_read(0, re[0], ad[0]));
        cmp32(tag, "b_rdata", b_rdata, m_read(1, re[1], ad[1]));
        cmp32(tag, "a_irq", 32'(a_irq), 32'(m_irq(0)));
        cmp32(tag, "b_irq", 32'(b_irq), 32'(m_irq(1)));
        @(posedge clk);
        for (int s = 0; s < 2; s++)
            for (int n = 0; n < 4; n++) begin
                nfull[s][n] = m_full[s][n];
                ndata[s][n] = m_data[s][n];
                if (we[s] && ad[s] == n) begin
                    nfull[s][n] = 1; ndata[s][n] = wd[s];
                end else if (re[1-s] && ad[1-s] == 4 + n) begin
                    nfull[s][n] = 0;
                end
                ngip[s][n] = m_gip[s][n];
                if (we[s] && ad[s] == 8 && wd[s][31-n]) ngip[s][n] = 0;
                if (m_gir[1-s][n]) ngip[s][n] = 1;
                ngir[s][n] = (we[s] && ad[s] == 9) ? wd[s][19-n] : 1'b0;
            end
        for (int s = 0; s < 2; s++)
            for (int n = 0; n < 4; n++) begin
                if (we[s] && ad[s] == 9) begin
                    m_gie[s][n] = wd[s][31-n];
                    m_rie[s][n] = wd[s][27-n];
                    m_tie[s][n] = wd[s][23-n];
                end
                m_full[s][n] = nfull[s][n];
                m_data[s][n] = ndata[s][n];
                m_gir[s][n]  = ngir[s][n];
                m_gip[s][n]  = ngip[s][n];
            end
        @(negedge clk);
    endtask

    task automatic drive(bit awe, bit are, int aad, logic [31:0] awd,
                         bit bwe, bit bre, int bad, logic [31:0] bwd);
        a_we = awe; a_re = are; a_addr = 4'(aad); a_wdata = awd;
        b_we = bwe; b_re = bre; b_addr = 4'(bad); b_wdata = bwd;
    endtask

    task automatic idle_read(string tag, int aad, int bad);
        drive(0, 1, aad, '0, 0, 1, bad, '0);
        step(tag);
    endtask

    initial begin
        #1_200_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state: status and control on both sides
        idle_read("R9", 8, 8);
        idle_read("R9", 9, 9);
        idle_read("R9", 0, 7);
        // R1 / R2: A pushes into slot 2, B pushes into slot 0
        drive(1, 0, 2, 32'hA5A5_0002, 1, 0, 0, 32'h1234_5678);
        step("R2");
        idle_read("R2", 8, 8);
        idle_read("R1", 2, 6);
        idle_read("R1", 4, 0);
        // R11 overwrite while full
        drive(1, 0, 2, 32'hDEAD_BEEF, 0, 0, 0, '0);
        step("R11");
        idle_read("R11", 8, 6);
        // R3 pop then status on both sides
        idle_read("R3", 8, 6);
        idle_read("R3", 8, 8);
        // R3 collision: B pops slot 1 while A pushes slot 1
        drive(1, 0, 1, 32'h0000_0111, 0, 0, 0, '0);
        step("R3");
        drive(1, 0, 1, 32'h0000_0222, 0, 1, 5, '0);
        step("R3");
        idle_read("R3", 8, 8);
        idle_read("R3", 1, 5);
        // R5 control layout, R8 irq from transmit-empty enables
        drive(1, 0, 9, 32'h00F0_FFFF, 0, 0, 0, '0);
        step("R5");
        idle_read("R8", 9, 8);
        // R6 ring doorbells 0 and 3 from A
        drive(1, 0, 9, 32'hF009_0000, 1, 0, 9, 32'hF000_0000);
        step("R6");
        idle_read("R6", 9, 8);
        idle_read("R6", 9, 8);
        idle_read("R8", 9, 8);
        // R7 write 0 has no effect, write 1 clears bit 0
        drive(0, 0, 0, '0, 1, 0, 8, 32'h0000_0000);
        step("R7");
        idle_read("R7", 8, 8);
        drive(0, 0, 0, '0, 1, 0, 8, 32'h8000_0000);
        step("R7");
        idle_read("R7", 8, 8);
        // R7 ring arriving with clear of doorbell 3
        drive(1, 0, 9, 32'hF001_0000, 0, 0, 0, '0);
        step("R7");
        drive(0, 0, 0, '0, 1, 0, 8, 32'h1000_0000);
        step("R7");
        idle_read("R7", 8, 8);
        // R10 unmapped and read-only writes
        drive(1, 1, 12, 32'hFFFF_FFFF, 1, 0, 15, 32'hFFFF_FFFF);
        step("R10");
        drive(1, 0, 8, 32'h0FFF_FFFF, 0, 1, 10, '0);
        step("R10");
        idle_read("R10", 8, 8);
        idle_read("R4", 8, 8);

        // R1..R11 mixed two-port traffic
        for (int i = 0; i < 3000; i++) begin
            int pa = $urandom_range(0, 99);
            int pb = $urandom_range(0, 99);
            drive(pa < 30, pa >= 30 && pa < 70, int'($urandom_range(0, 11)), $urandom(),
                  pb < 30, pb >= 30 && pb < 70, int'($urandom_range(0, 11)), $urandom());
            step("R8");
        end
        drive(0, 0, 0, '0, 0, 0, 0, '0);
        step("R4");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule